// File: doc/BRIEF.md
# Synchronous Burst Flash Read Port

This block is the device-side read path of a NOR-style flash that answers synchronous burst reads. A host starts a read by pulling the address-latch strobe low on an active bus-clock edge while chip enable is low. The block captures the start address and the read mode, then counts out a programmable first-access latency. After that it presents one 16-bit word per bus-clock edge from a computed array model. The address counter steps by one on every edge and runs on without wrapping at any block boundary.

The bus clock arrives as a strobe, `bclk_en`, sampled by the core clock `clk`. A cycle without the strobe is a halted bus clock. The host may freeze a burst at any point by halting the bus clock and raising output enable. Once it lowers output enable and restarts the clock, the burst continues at the same word. If the freeze falls inside the first-access latency, internal sensing keeps counting that latency down. The first word can therefore be ready as soon as the burst resumes.

The outgoing word stream is marked by `dq_valid` and has no ready input. Back-pressure works by withholding the bus-clock strobe. A word shown with `dq_valid` high is consumed by the next cycle that carries `bclk_en`, and nothing advances without that strobe. The status, identifier and query spaces give a single valid word per latch. WAIT is driven whenever chip enable is low, including while output enable is high.

Top module: `fbr_burst_port`

## Requirements
- R1: After reset no burst is active. `dq_valid`, `dout` and `dout_en` are 0 and `wait_o` is 1. `wait_en` follows `ce_n`.
- R2: On a cycle with `bclk_en`=1, `ce_n`=0 and `adv_n`=0, the block captures `addr`, `mode` and `lat_cfg` as the remaining latency, and any running burst restarts. A cycle with `ce_n`=1 ends the burst.
- R3: Each strobe cycle with remaining latency above zero lowers it by one. Data is valid only once the remaining latency is zero, so with no suspend the first word is present after `lat_cfg` strobe cycles that follow the latch cycle.
- R4: In array mode (`mode`=2'b00), each strobe cycle in the data phase advances the address by one, with no wrap at any block boundary. The word at address a is ((a[15:0] * 16'h9E37) mod 2^16) XOR 16'h5A5A.
- R5: A cycle without `bclk_en` leaves the burst address unchanged. After a suspend with `oe_n`=1, resuming returns exactly the word that was pending.
- R6: During the latency, each cycle with `ce_n`=0, `oe_n`=1 and no strobe also lowers the remaining latency by one. A burst suspended long enough therefore shows its first word on resume without further strobes.
- R7: `dout_en` is 1 only when `ce_n`=0 and `oe_n`=0. `dq_valid` requires `dout_en`. `dout` is 0 whenever `dq_valid` is 0.
- R8: `wait_en` equals NOT `ce_n`: WAIT stays driven while `oe_n` is 1.
- R9: In array mode `wait_o` is 0 exactly in the data phase of an active burst, including while it is suspended. Otherwise it is 1.
- R10: In the non-array modes (status 2'b01, identifier 2'b10, query 2'b11), `wait_o` is 1 on every cycle.
- R11: In a non-array mode only the first data-phase word after the latch is valid, and later strobes show `dq_valid`=0. The status word is 16'h0080. The identifier word is 16'h0020 at an even address and 16'h88C4 at an odd one. The query word is {8'h00, addr[7:0] XOR 8'h51}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_en | input | 1 | Active bus-clock edge strobe; 0 means the bus clock is halted |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address latch strobe, active low |
| addr | input | 20 | Start address |
| mode | input | 2 | Read space: 00 array, 01 status, 10 identifier, 11 query |
| lat_cfg | input | 3 | First-access latency in bus-clock edges |
| dout | output | 16 | Read word |
| dout_en | output | 1 | Data pins driven (0 models high impedance) |
| dq_valid | output | 1 | `dout` carries a valid word |
| wait_o | output | 1 | WAIT level, 1 = data not ready |
| wait_en | output | 1 | WAIT pin driven |

## Verification
Two functions can fall in the same cycle: a fresh latch strobe on the very edge where a running array burst would step its address. The bench provokes this by lowering `adv_n` in the middle of a streaming burst. The reference model requires the restart to win, so the following cycles show WAIT asserted for the new latency and then the words of the new address. A second overlap, a suspend that starts while latency remains, is judged by the first word appearing on resume with no extra strobe.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'b00,
    MODE_STATUS = 2'b01,
    MODE_IDENT  = 2'b10,
    MODE_QUERY  = 2'b11
  } rd_mode_e;

  localparam logic [15:0] STATUS_READY_WORD = 16'h0080;
endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_edge,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  rd_mode_e          mode,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic [ADDR_W-1:0] ptr_o,
  output rd_mode_e          mode_o,
  output logic              data_phase_o,
  output logic              spent_o
);
  logic              active_q;
  logic [LAT_W-1:0]  remain_q;
  logic [ADDR_W-1:0] ptr_q;
  rd_mode_e          mode_q;
  logic              spent_q;

  logic in_latency;
  assign in_latency = active_q && (remain_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      ptr_q    <= '0;
      mode_q   <= MODE_ARRAY;
      spent_q  <= 1'b0;
    end else if (ce_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      spent_q  <= 1'b0;
    end else if (bus_edge && !adv_n) begin
      active_q <= 1'b1;
      ptr_q    <= addr;
      mode_q   <= mode;
      remain_q <= lat_cfg;
      spent_q  <= 1'b0;
    end else if (bus_edge && in_latency) begin
      remain_q <= remain_q - LAT_W'(1);
    end else if (bus_edge && active_q) begin
      ptr_q <= ptr_q + ADDR_W'(1);
      if (mode_q != MODE_ARRAY) spent_q <= 1'b1;
    end else if (!bus_edge && oe_n && in_latency) begin
      // array sensing keeps running while the bus clock is frozen
      remain_q <= remain_q - LAT_W'(1);
    end
  end

  assign ptr_o        = ptr_q;
  assign mode_o       = mode_q;
  assign data_phase_o = active_q && (remain_q == '0);
  assign spent_o      = spent_q;
endmodule

// File: rtl/fbr_array.sv
module fbr_array #(
  parameter logic [15:0] MULT = 16'h9E37,
  parameter logic [15:0] SEED = 16'h5A5A
) (
  input  logic [15:0] addr_lo,
  output logic [15:0] word
);
  logic [15:0] prod;
  assign prod = addr_lo * MULT;
  assign word = prod ^ SEED;
endmodule

// File: rtl/fbr_regspace.sv
module fbr_regspace
  import fbr_pkg::*;
#(
  parameter logic [15:0] MAKER_ID  = 16'h0020,
  parameter logic [15:0] DEVICE_ID = 16'h88C4,
  parameter logic [7:0]  QUERY_KEY = 8'h51
) (
  input  rd_mode_e    mode,
  input  logic [7:0]  addr_lo,
  output logic [15:0] word
);
  always_comb begin
    unique case (mode)
      MODE_STATUS: word = STATUS_READY_WORD;
      MODE_IDENT:  word = addr_lo[0] ? DEVICE_ID : MAKER_ID;
      MODE_QUERY:  word = {8'h00, addr_lo ^ QUERY_KEY};
      default:     word = '0;
    endcase
  end
endmodule

// File: rtl/fbr_burst_port.sv
module fbr_burst_port
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LAT_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dq_valid,
  output logic              wait_o,
  output logic              wait_en
);
  localparam int LO_W = (ADDR_W < 16) ? ADDR_W : 16;

  logic [ADDR_W-1:0] burst_ptr;
  rd_mode_e          burst_mode;
  logic              in_data;
  logic              spent;
  logic [15:0]       ptr_lo;
  logic [15:0]       arr_word;
  logic [15:0]       reg_word;
  logic              word_ok;
  logic              is_array;

  fbr_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_edge     (bclk_en),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .adv_n        (adv_n),
    .addr         (addr),
    .mode         (rd_mode_e'(mode)),
    .lat_cfg      (lat_cfg),
    .ptr_o        (burst_ptr),
    .mode_o       (burst_mode),
    .data_phase_o (in_data),
    .spent_o      (spent)
  );

  assign ptr_lo = 16'(burst_ptr[LO_W-1:0]);

  fbr_array u_array (
    .addr_lo (ptr_lo),
    .word    (arr_word)
  );

  fbr_regspace u_regs (
    .mode    (burst_mode),
    .addr_lo (ptr_lo[7:0]),
    .word    (reg_word)
  );

  assign is_array = (burst_mode == MODE_ARRAY);
  assign word_ok  = in_data && (is_array || !spent);
  assign dout_en  = !ce_n && !oe_n;
  assign dq_valid = dout_en && word_ok;
  assign dout     = dq_valid ? DATA_W'(is_array ? arr_word : reg_word) : '0;
  assign wait_en  = !ce_n;
  assign wait_o   = !(in_data && is_array);
endmodule

// File: rtl/fbr_burst_port_chk.sv
module fbr_burst_port_chk
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LAT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk_en,
  input logic              ce_n,
  input logic              adv_n,
  input logic [LAT_W-1:0]  lat_cfg,
  input logic              dq_valid,
  input logic              wait_o,
  input logic              wait_en,
  input logic [ADDR_W-1:0] ptr,
  input rd_mode_e          mode_q,
  input logic              data_phase
);
  assert_first_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && !ce_n && !adv_n && lat_cfg != '0) |=> !dq_valid);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && !ce_n && adv_n && data_phase) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> $stable(ptr));

  assert_wait_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_o && !bclk_en && !ce_n) |=> !wait_o);

  assert_wait_array_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && !wait_o) |-> (mode_q == MODE_ARRAY));

  assert_one_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && bclk_en && adv_n && !ce_n && mode_q != MODE_ARRAY) |=> !dq_valid);
endmodule

bind fbr_burst_port fbr_burst_port_chk #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk_en    (bclk_en),
  .ce_n       (ce_n),
  .adv_n      (adv_n),
  .lat_cfg    (lat_cfg),
  .dq_valid   (dq_valid),
  .wait_o     (wait_o),
  .wait_en    (wait_en),
  .ptr        (burst_ptr),
  .mode_q     (burst_mode),
  .data_phase (in_data)
);

// File: tb/sim_fbr_burst_port.sv
`timescale 1ns/1ps
module sim_fbr_burst_port;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk_en = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    mode = 2'b00;
  logic [2:0]    lat_cfg = 3'd0;
  logic [15:0]   dout;
  logic          dout_en, dq_valid, wait_o, wait_en;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_act = 0;
  int m_lat = 0;
  int m_ptr = 0;
  int m_mode = 0;
  bit m_spent = 0;

  always #2.5 clk = ~clk;

  fbr_burst_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .ce_n(ce_n), .oe_n(oe_n),
    .adv_n(adv_n), .addr(addr), .mode(mode), .lat_cfg(lat_cfg),
    .dout(dout), .dout_en(dout_en), .dq_valid(dq_valid),
    .wait_o(wait_o), .wait_en(wait_en)
  );

  function automatic logic [15:0] arr_word(int a);
    logic [15:0] lo;
    logic [15:0] p;
    lo = 16'(a);
    p  = lo * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] reg_word(int md, int a);
    logic [7:0] lo;
    lo = 8'(a);
    if (md == 1) return 16'h0080;
    if (md == 2) return lo[0] ? 16'h88C4 : 16'h0020;
    return {8'h00, lo ^ 8'h51};
  endfunction

  task automatic check1(string tag, string sig, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, sig, got, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    bit dp, ok, den, val;
    int exp_d;
    dp  = m_act && (m_lat == 0);
    ok  = dp && (m_mode == 0 || !m_spent);
    den = !ce_n && !oe_n;
    val = den && ok;
    exp_d = val ? ((m_mode == 0) ? int'(arr_word(m_ptr)) : int'(reg_word(m_mode, m_ptr))) : 0;
    check1({tag, "/R3"}, "dq_valid", int'(dq_valid), int'(val));
    check1({tag, (m_mode == 0) ? "/R4" : "/R11"}, "dout", int'(dout), exp_d);
    check1({tag, "/R7"}, "dout_en", int'(dout_en), int'(den));
    check1({tag, "/R8"}, "wait_en", int'(wait_en), int'(!ce_n));
    check1({tag, (m_mode == 0) ? "/R9" : "/R10"}, "wait_o", int'(wait_o),
           int'(!(dp && m_mode == 0)));
  endtask

  task automatic model_step();
    if (ce_n) begin
      m_act = 0; m_lat = 0; m_spent = 0;
    end else if (bclk_en && !adv_n) begin
      m_act = 1; m_ptr = int'(addr); m_mode = int'(mode);
      m_lat = int'(lat_cfg); m_spent = 0;
    end else if (bclk_en && m_act) begin
      if (m_lat > 0) m_lat--;
      else begin
        m_ptr = (m_ptr + 1) % (1 << AW);
        if (m_mode != 0) m_spent = 1;
      end
    end else if (!bclk_en && oe_n && m_act && m_lat > 0) begin
      m_lat--;
    end
  endtask

  task automatic cyc(string tag, bit e, bit c, bit o, bit a, int ad, int md, int lt);
    bclk_en = e; ce_n = c; oe_n = o; adv_n = a;
    addr = AW'(ad); mode = 2'(md); lat_cfg = 3'(lt);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic run(string tag, int n, bit o);
    for (int i = 0; i < n; i++) cyc(tag, 1, 0, o, 1, 0, 0, 0);
  endtask

  task automatic pause(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 1, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1_reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1_idle");

    // R2/R4: array burst across a 256-word boundary, latency 3
    cyc("R2_latch", 1, 0, 0, 0, 20'h000FD, 0, 3);
    run("R4_stream", 9, 0);

    // R5: suspend after data, then resume at the pending word
    pause("R5_suspend", 4);
    run("R5_resume", 3, 0);

    // R6: suspend during latency lets sensing finish
    cyc("R6_latch", 1, 0, 0, 0, 20'h12340, 0, 6);
    run("R6_edge", 1, 0);
    pause("R6_sense", 7);
    cyc("R6_hold", 0, 0, 0, 1, 0, 0, 0);
    run("R6_resume", 3, 0);

    // R2: relatch in the middle of a streaming burst
    cyc("R2_start", 1, 0, 0, 0, 20'h00500, 0, 2);
    run("R2_run", 4, 0);
    cyc("R2_relatch", 1, 0, 0, 0, 20'hFFFFE, 0, 2);
    run("R2_new", 5, 0);

    // slower bus clock with outputs enabled: gaps do not shorten latency
    cyc("R3_slow", 1, 0, 0, 0, 20'h00042, 0, 4);
    for (int i = 0; i < 6; i++) begin
      cyc("R3_gap", 0, 0, 0, 1, 0, 0, 0);
      cyc("R3_edge", 1, 0, 0, 1, 0, 0, 0);
    end

    // R8: WAIT driven with outputs off; R1-style idle after chip disable
    run("R8_oe_high", 2, 1);
    cyc("R2_ce_off", 0, 1, 1, 1, 0, 0, 0);
    run("R7_ce_off", 2, 0);
    cyc("R7_ce_off2", 1, 1, 0, 1, 0, 0, 0);

    // R11/R10: single reads of the other spaces
    cyc("R11_status", 1, 0, 0, 0, 20'h00007, 1, 2);
    run("R11_status_run", 5, 0);
    cyc("R11_id_even", 1, 0, 0, 0, 20'h00000, 2, 1);
    run("R11_id_run", 4, 0);
    cyc("R11_id_odd", 1, 0, 0, 0, 20'h00001, 2, 0);
    run("R11_id_run", 3, 0);
    cyc("R11_query", 1, 0, 0, 0, 20'h000A3, 3, 3);
    run("R10_query_run", 3, 0);
    pause("R10_pause", 2);
    run("R10_query_run2", 3, 0);

    // R3: zero latency array read
    cyc("R3_zero", 1, 0, 0, 0, 20'h00020, 0, 0);
    run("R3_zero_run", 3, 0);
    cyc("R2_end", 0, 1, 1, 1, 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule